// File: doc/BRIEF.md
# Pushbutton Input Port with Sticky Press Capture

This block is a small register-mapped input port for a bank of four pushbuttons. Each raw button level is brought into the local clock domain through a two-flop synchronizer. The synchronized levels can be read directly as the live pressed state. A press counts as complete when the button goes down and then comes back up. The block records each completed press in a per-button sticky capture bit, and that bit stays set until software clears it.

A per-button enable mask is combined with the capture bits to drive one level interrupt line. The line stays high while any enabled button has a capture bit set. Software clears capture bits by writing ones to them, so writing back a value just read clears exactly the presses it observed. Register access uses a word index, separate read and write strobes, and 32-bit data. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `push_port`

## Requirements
- R1: After reset, the live state, the mask and all capture bits read as zero, and `irq` is low.
- R2: A read of word index 0 returns the synchronized pressed state, with button i in bit i (1 = pressed). A level change at `key_raw` becomes visible on the second rising clock edge after it is applied.
- R3: A write to word index 2 loads bits [3:0] of `wdata` into the mask, and a read of word index 2 returns the mask. A mask bit of 1 enables the interrupt for that button.
- R4: A capture bit, read at word index 3 in bit i for button i, sets only when its synchronized button goes from pressed to released. Pressing a button without releasing it does not set the bit.
- R5: Writing to word index 3 clears every capture bit whose `wdata` bit is 1 and leaves the others unchanged. Writing back the value just read therefore clears all captured bits.
- R6: `irq` is high exactly while the bitwise AND of the capture bits and the mask is nonzero.
- R7: If a clear write and a new release edge hit the same capture bit in the same cycle, the bit stays set.
- R8: Bits [31:4] of every read, and all bits of a read at word index 1, are zero. Writes to word index 0 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Word index of the register |
| rd_en | input | 1 | Read strobe; `rdata` updates on the same edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| key_raw | input | 4 | Asynchronous button levels, 1 = pressed |
| irq | output | 1 | Level interrupt: any enabled capture bit set |

## Verification
Two functions can act on a capture bit in the same clock cycle: a software clear write, and the hardware setting the bit on a release edge. The bench releases button 0 while its capture bit is already set. It counts the two synchronizer edges and then issues the clear write so that the write is sampled on the same edge where the release edge is detected. The bit must still read 1 afterwards. A second clear with no edge present must then reset it, which shows that the first clear lost only because of the collision.

// File: rtl/push_port.sv
module push_port #(
  parameter int NKEYS      = 4,
  parameter int DW         = 32,
  parameter int AW         = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NKEYS-1:0] key_raw,
  output logic          irq
);
  localparam logic [AW-1:0] IDX_LIVE = AW'(0);
  localparam logic [AW-1:0] IDX_MASK = AW'(2);
  localparam logic [AW-1:0] IDX_CAPT = AW'(3);
  localparam int PAD = DW - NKEYS;

  logic [SYNC_DEPTH-1:0][NKEYS-1:0] sync_pipe;
  logic [NKEYS-1:0] key_now, key_last, edge_hit;
  logic [NKEYS-1:0] mask_q, cap_q, clr_bits;
  logic _unused_wdata;

  assign _unused_wdata = &{1'b0, wdata[DW-1:NKEYS]};

  assign key_now  = sync_pipe[SYNC_DEPTH-1];
  assign edge_hit = key_last & ~key_now;
  assign clr_bits = (wr_en && addr == IDX_CAPT) ? wdata[NKEYS-1:0] : '0;
  assign irq      = |(cap_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pipe <= '0;
      key_last  <= '0;
    end else begin
      sync_pipe <= {sync_pipe[SYNC_DEPTH-2:0], key_raw};
      key_last  <= key_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_en && addr == IDX_MASK)
        mask_q <= wdata[NKEYS-1:0];
      cap_q <= (cap_q & ~clr_bits) | edge_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        IDX_LIVE: rdata <= {{PAD{1'b0}}, key_now};
        IDX_MASK: rdata <= {{PAD{1'b0}}, mask_q};
        IDX_CAPT: rdata <= {{PAD{1'b0}}, cap_q};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

module push_port_chk #(
  parameter int NKEYS = 4,
  parameter int AW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NKEYS-1:0] wdata_lo,
  input logic             irq,
  input logic [NKEYS-1:0] mask_q,
  input logic [NKEYS-1:0] cap_q,
  input logic [NKEYS-1:0] key_now,
  input logic [NKEYS-1:0] key_last
);
  logic [NKEYS-1:0] rel;
  assign rel = key_last & ~key_now;

  // R4 / R7: a release edge always leaves its capture bit set
  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel != '0) |=> ((cap_q & $past(rel)) == $past(rel)));

  // R4: capture bits rise only from a release edge
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_q & ~$past(cap_q) & ~$past(rel)) == '0));

  // R5: a clear with no competing edge empties the named bits
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> ((cap_q & $past(wdata_lo & ~rel)) == '0));

  // R3: mask write lands on the next edge
  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> (mask_q == $past(wdata_lo)));

  // R6: the interrupt needs an enabled, captured bit
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && cap_q != '0));

  // R6: an enabled captured bit raises the interrupt
  p_irq_raised_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_q & mask_q) != '0) |-> irq);
endmodule

bind push_port push_port_chk #(.NKEYS(NKEYS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata_lo(wdata[NKEYS-1:0]), .irq(irq), .mask_q(mask_q),
  .cap_q(cap_q), .key_now(key_now), .key_last(key_last)
);

// File: tb/sim_push_port.sv
module sim_push_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  key_raw = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  push_port u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .key_raw(key_raw), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at one
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(2'd0, v); check("R1 live", v, 32'h0);
    bus_read(2'd2, v); check("R1 mask", v, 32'h0);
    bus_read(2'd3, v); check("R1 capture", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_press_release();
    logic [31:0] v;
    key_raw = 4'b1010;
    @(negedge clk);
    bus_read(2'd0, v); check("R2 live after one edge", v, 32'h0);
    settle();
    bus_read(2'd0, v); check("R2 live pressed", v, 32'h0000_000A);
    bus_read(2'd3, v); check("R4 no capture while held", v, 32'h0);
    key_raw = 4'b0000;
    settle();
    bus_read(2'd0, v); check("R2 live released", v, 32'h0);
    bus_read(2'd3, v); check("R4 capture after release", v, 32'h0000_000A);
    bus_read(2'd1, v); check("R8 unmapped word", v, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    bus_write(2'd2, 32'hFFFF_FFF5);
    bus_read(2'd2, v); check("R3 R8 mask readback", v, 32'h0000_0005);
    check("R6 irq disjoint mask", {31'h0, irq}, 32'h0);
    bus_write(2'd2, 32'h0000_0002);
    check("R6 irq enabled bit", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_write(2'd3, 32'h0000_0002);
    bus_read(2'd3, v); check("R5 clear one bit", v, 32'h0000_0008);
    check("R6 irq after clear", {31'h0, irq}, 32'h0);
    bus_write(2'd3, 32'h0);
    bus_read(2'd3, v); check("R5 zero write keeps", v, 32'h0000_0008);
    bus_write(2'd3, v);
    bus_read(2'd3, v); check("R5 write-back clears", v, 32'h0);
  endtask

  task automatic t_data_write();
    logic [31:0] v;
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, v); check("R8 live unchanged", v, 32'h0);
    bus_read(2'd3, v); check("R8 capture unchanged", v, 32'h0);
    bus_read(2'd2, v); check("R8 mask unchanged", v, 32'h0000_0002);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    key_raw = 4'b0001; settle();
    key_raw = 4'b0000; settle();
    bus_read(2'd3, v); check("R4 key0 captured", v, 32'h1);
    key_raw = 4'b0001; settle();
    key_raw = 4'b0000;
    @(negedge clk); @(negedge clk);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3, v); check("R7 edge beats clear", v, 32'h1);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3, v); check("R7 later clear works", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_press_release();
    t_mask_irq();
    t_clear();
    t_data_write();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1-watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule